// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between the raw control pins of a processor core and the core's interrupt and run-control logic. Each pin update arrives as a write of one pin index and its new level. The block keeps the last level seen on every pin and acts only when a write really changes that level. A changed level becomes one of several things: a pending-interrupt bit, a halt, a one-cycle core reset pulse, or the run/freeze control of the time base. Each pin has its own rule. Some are level-sensitive, one reacts only to its falling edge, and the reset and checkstop pins react only when they are asserted.

Software drops pending bits through a clear port that takes a mask. A combined interrupt request is high while any pending bit is set. Interrupt priority, vectoring and the time-base counter belong to neighbouring blocks.

Top module: `irqc_pin_cond`

## Requirements
- R1: A pin write whose level equals that pin's stored level causes no event and changes no output. For example, a second write of 1 to the hard-reset pin gives no reset pulse.
- R2: Pin index 0 (external interrupt) and pin index 1 (system management) are level-sensitive and active-high. Pending bit 0 and pending bit 1 take the new level of the matching pin on each change.
- R3: Pin index 2 (machine check) sets pending bit 2 only on a 1-to-0 change. Its 0-to-1 change does nothing. Bit 2 stays set until software clears it.
- R4: A 0-to-1 change on pin index 3 (checkstop) sets `halted`. A 1-to-0 change leaves `halted` set. Only a hard-reset pulse or the block reset clears it.
- R5: A 0-to-1 change on pin index 4 (hard reset) drives `core_rst` high for exactly one cycle and clears `halted`. A 1-to-0 change has no effect.
- R6: Pin index 5 (soft reset) is level-sensitive. Pending bit 3 takes the new level of that pin on each change.
- R7: `tb_run` equals the stored level of pin index 6 (time-base enable). Changes on that pin never alter any pending bit.
- R8: `irq_req` is high exactly when the pending vector is nonzero.
- R9: A write with pin index 7 (outside the defined set) is ignored. It changes no stored pin level and no output.
- R10: `clr_en` with `clr_mask` clears the masked pending bits. If a pin event sets or updates a bit in the same cycle, the pin event wins.
- R11: The synchronous reset `rst` zeroes all stored pin levels and the pending vector, and holds `irq_req`, `halted`, `core_rst` and `tb_run` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_wr | input | 1 | Pin level update strobe |
| pin_idx | input | IDX_W (3) | Index of the updated pin |
| pin_lvl | input | 1 | New level of the pin |
| clr_en | input | 1 | Pending clear strobe |
| clr_mask | input | 4 | Pending bits to clear |
| pend | output | 4 | Pending interrupt vector |
| irq_req | output | 1 | Combined interrupt request |
| halted | output | 1 | Core halted by checkstop |
| core_rst | output | 1 | One-cycle core reset pulse |
| tb_run | output | 1 | Time base run (1) / freeze (0) |

## Verification
Every output is registered once after the input edge. A write or clear driven before rising edge N therefore shows on `pend`, `irq_req`, `halted`, `tb_run` and `core_rst` after edge N. The `core_rst` pulse is gone again after edge N+1. The bench drives inputs on the falling edge and compares every output on the next falling edge against a model kept in the bench. After each write it also checks an idle cycle, which confirms the reset pulse is one cycle wide. The stimulus sweeps every pin index and level pair, some of them repeated. It then runs a long pseudo-random sequence that mixes writes and masked clears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int NUM_PINS = 7;
   localparam int NUM_PEND = 4;

   localparam int PIN_EXT   = 0;
   localparam int PIN_SMI   = 1;
   localparam int PIN_MCHK  = 2;
   localparam int PIN_CSTOP = 3;
   localparam int PIN_HRST  = 4;
   localparam int PIN_SRST  = 5;
   localparam int PIN_TBE   = 6;

   localparam int PB_EXT  = 0;
   localparam int PB_SMI  = 1;
   localparam int PB_MCHK = 2;
   localparam int PB_SRST = 3;

   typedef enum logic [0:0] {
      PM_LEVEL = 1'b0,
      PM_FALL  = 1'b1
   } pend_mode_e;

   function automatic int pend_src(input int b);
      case (b)
         PB_EXT:  return PIN_EXT;
         PB_SMI:  return PIN_SMI;
         PB_MCHK: return PIN_MCHK;
         default: return PIN_SRST;
      endcase
   endfunction

   function automatic pend_mode_e pend_mode(input int b);
      return (b == PB_MCHK) ? PM_FALL : PM_LEVEL;
   endfunction

endpackage

// File: rtl/irqc_pin_track.sv
module irqc_pin_track
   import irqc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr,
   input  logic [IDX_W-1:0]    idx,
   input  logic                lvl,
   output logic [NUM_PINS-1:0] state_o,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] fall_o
);

   logic [NUM_PINS-1:0] state_q;
   logic [NUM_PINS-1:0] sel;
   logic                idx_ok;

   assign idx_ok = (32'(idx) < NUM_PINS);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign sel[p]    = wr && (idx == IDX_W'(p));
      assign rise_o[p] = sel[p] &&  lvl && !state_q[p];
      assign fall_o[p] = sel[p] && !lvl &&  state_q[p];

      always_ff @(posedge clk) begin
         if (rst)
            state_q[p] <= 1'b0;
         else if (rise_o[p] || fall_o[p])
            state_q[p] <= lvl;
      end
   end

   assign state_o = state_q;

   // R9
   bad_idx_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && !idx_ok) |=> $stable(state_q));

   // R1
   same_lvl_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && idx_ok && (state_q[idx] == lvl)) |-> (rise_o == '0 && fall_o == '0));

endmodule

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg
   import irqc_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] rise_i,
   input  logic [NUM_PINS-1:0] fall_i,
   input  logic                clr_en,
   input  logic [NUM_PEND-1:0] clr_mask,
   output logic [NUM_PEND-1:0] pend_o,
   output logic [NUM_PEND-1:0] pend_nxt_o
);

   logic [NUM_PEND-1:0] pend_q;
   logic [NUM_PEND-1:0] pend_d;

   for (genvar b = 0; b < NUM_PEND; b++) begin : g_bit
      localparam int SRC = pend_src(b);
      logic cleared;
      assign cleared = pend_q[b] && !(clr_en && clr_mask[b]);

      if (pend_mode(b) == PM_FALL) begin : g_fall
         assign pend_d[b] = fall_i[SRC] ? 1'b1 : cleared;
      end else begin : g_level
         assign pend_d[b] = rise_i[SRC] ? 1'b1 :
                            fall_i[SRC] ? 1'b0 : cleared;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= pend_d;
   end

   assign pend_o     = pend_q;
   assign pend_nxt_o = pend_d;

   // R3
   mchk_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[PB_MCHK]) |-> $past(fall_i[PIN_MCHK]));

   // R3
   mchk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q[PB_MCHK] && !(clr_en && clr_mask[PB_MCHK])) |=> pend_q[PB_MCHK]);

   // R7
   tbe_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
      ((rise_i[PIN_TBE] || fall_i[PIN_TBE]) && !clr_en) |=> $stable(pend_q));

endmodule

// File: rtl/irqc_run_ctrl.sv
module irqc_run_ctrl
   import irqc_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] rise_i,
   input  logic [NUM_PINS-1:0] state_i,
   output logic                halted_o,
   output logic                core_rst_o,
   output logic                tb_run_o
);

   logic halt_q;
   logic crst_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         halt_q <= 1'b0;
         crst_q <= 1'b0;
      end else begin
         crst_q <= rise_i[PIN_HRST];
         if (rise_i[PIN_HRST])
            halt_q <= 1'b0;
         else if (rise_i[PIN_CSTOP])
            halt_q <= 1'b1;
      end
   end

   assign halted_o   = halt_q;
   assign core_rst_o = crst_q;
   assign tb_run_o   = state_i[PIN_TBE];

   // R5
   crst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      crst_q |=> !crst_q);

   // R4
   halt_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(halt_q) |-> crst_q);

endmodule

// File: rtl/irqc_pin_cond.sv
module irqc_pin_cond
   import irqc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pin_wr,
   input  logic [IDX_W-1:0]    pin_idx,
   input  logic                pin_lvl,
   input  logic                clr_en,
   input  logic [NUM_PEND-1:0] clr_mask,
   output logic [NUM_PEND-1:0] pend,
   output logic                irq_req,
   output logic                halted,
   output logic                core_rst,
   output logic                tb_run
);

   if (IDX_W < $clog2(NUM_PINS)) begin : g_bad_width
      $error("IDX_W too narrow for the pin set");
   end

   logic [NUM_PINS-1:0] pin_state;
   logic [NUM_PINS-1:0] pin_rise;
   logic [NUM_PINS-1:0] pin_fall;
   logic [NUM_PEND-1:0] pend_nxt;
   logic                irq_q;

   irqc_pin_track #(.IDX_W(IDX_W)) u_track (
      .clk     (clk),
      .rst     (rst),
      .wr      (pin_wr),
      .idx     (pin_idx),
      .lvl     (pin_lvl),
      .state_o (pin_state),
      .rise_o  (pin_rise),
      .fall_o  (pin_fall)
   );

   irqc_pend_reg u_pend (
      .clk        (clk),
      .rst        (rst),
      .rise_i     (pin_rise),
      .fall_i     (pin_fall),
      .clr_en     (clr_en),
      .clr_mask   (clr_mask),
      .pend_o     (pend),
      .pend_nxt_o (pend_nxt)
   );

   irqc_run_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .rise_i     (pin_rise),
      .state_i    (pin_state),
      .halted_o   (halted),
      .core_rst_o (core_rst),
      .tb_run_o   (tb_run)
   );

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |pend_nxt;
   end

   assign irq_req = irq_q;

   // R8
   irq_any_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req == (pend != '0));

   // R11
   rst_quiet_chk: assert property (@(posedge clk)
      rst |=> (pend == '0 && !irq_req && !halted && !core_rst && !tb_run));

endmodule

// File: tb/irqc_pin_cond_tb.sv
module irqc_pin_cond_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       pin_wr;
   logic [2:0] pin_idx;
   logic       pin_lvl;
   logic       clr_en;
   logic [3:0] clr_mask;
   logic [3:0] pend;
   logic       irq_req, halted, core_rst, tb_run;

   int n_chk = 0;
   int n_bad = 0;

   logic [6:0] m_pin;
   logic [3:0] m_pend;
   logic       m_halt, m_crst;

   always #10 clk = ~clk;

   irqc_pin_cond #(.IDX_W(3)) u_dut (
      .clk(clk), .rst(rst), .pin_wr(pin_wr), .pin_idx(pin_idx),
      .pin_lvl(pin_lvl), .clr_en(clr_en), .clr_mask(clr_mask),
      .pend(pend), .irq_req(irq_req), .halted(halted),
      .core_rst(core_rst), .tb_run(tb_run)
   );

   task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_all(input string ctx);
      chk(pend, m_pend, {ctx, " R2/R3/R6/R10 pend"});
      chk({3'b0, irq_req}, {3'b0, |m_pend}, {ctx, " R8 irq_req"});
      chk({3'b0, halted}, {3'b0, m_halt}, {ctx, " R4 halted"});
      chk({3'b0, core_rst}, {3'b0, m_crst}, {ctx, " R5 core_rst"});
      chk({3'b0, tb_run}, {3'b0, m_pin[6]}, {ctx, " R7 tb_run"});
   endtask

   task automatic model_reset();
      m_pin = '0; m_pend = '0; m_halt = 1'b0; m_crst = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pin_wr = 1'b0; clr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk_all("R11 reset");
   endtask

   task automatic op(input logic wr, input logic [2:0] idx, input logic lvl,
                     input logic ce, input logic [3:0] cm);
      logic rise, fall;
      pin_wr = wr; pin_idx = idx; pin_lvl = lvl; clr_en = ce; clr_mask = cm;
      rise = 1'b0; fall = 1'b0;
      if (wr && idx < 3'd7) begin
         rise = lvl && !m_pin[idx];
         fall = !lvl && m_pin[idx];
      end
      if (ce) m_pend = m_pend & ~cm;
      m_crst = 1'b0;
      if (rise || fall) begin
         case (idx)
            3'd0: m_pend[0] = lvl;
            3'd1: m_pend[1] = lvl;
            3'd2: if (fall) m_pend[2] = 1'b1;
            3'd3: if (rise) m_halt = 1'b1;
            3'd4: if (rise) begin m_crst = 1'b1; m_halt = 1'b0; end
            3'd5: m_pend[3] = lvl;
            default: ;
         endcase
         m_pin[idx] = lvl;
      end
      @(negedge clk);
      pin_wr = 1'b0; clr_en = 1'b0;
      chk_all(wr ? "R1/R9 write" : "R10 clear");
      m_crst = 1'b0;
      @(negedge clk);
      chk_all("R5 idle");
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      rst = 1'b1; pin_wr = 1'b0; pin_idx = '0; pin_lvl = 1'b0;
      clr_en = 1'b0; clr_mask = '0;
      model_reset();
      do_reset();

      // R1 R2 R3 R4 R5 R6 R7 R9: sweep every pin/level pair, each twice
      for (int i = 0; i < 8; i++) begin
         for (int l = 1; l >= 0; l--) begin
            op(1'b1, 3'(i), l[0], 1'b0, 4'h0);
            op(1'b1, 3'(i), l[0], 1'b0, 4'h0);
         end
      end
      // R3: machine check is sticky until cleared
      op(1'b1, 3'd2, 1'b1, 1'b0, 4'h0);
      op(1'b1, 3'd2, 1'b0, 1'b0, 4'h0);
      op(1'b0, 3'd0, 1'b0, 1'b1, 4'h4);
      // R4: checkstop halt, deassert keeps halt, hard reset clears
      op(1'b1, 3'd3, 1'b1, 1'b0, 4'h0);
      op(1'b1, 3'd3, 1'b0, 1'b0, 4'h0);
      op(1'b1, 3'd4, 1'b1, 1'b0, 4'h0);
      op(1'b1, 3'd4, 1'b0, 1'b0, 4'h0);
      // R10: event wins over clear of same bit
      op(1'b1, 3'd0, 1'b1, 1'b1, 4'hF);
      // R7: time base enable does not touch ext pending
      op(1'b1, 3'd6, 1'b1, 1'b0, 4'h0);
      op(1'b1, 3'd6, 1'b0, 1'b0, 4'h0);
      // R4 R11: halt then block reset
      op(1'b1, 3'd3, 1'b1, 1'b0, 4'h0);
      do_reset();

      seed = 32'h1234_5678;
      for (int k = 0; k < 2000; k++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         op(seed[24] | seed[25], seed[18:16], seed[20], seed[27] & seed[28], seed[11:8]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule